// File: doc/BRIEF.md
# Sequential Booth Multiplier (radix 2)

This block multiplies two signed two's-complement operands over several clock cycles, using the radix-2 Booth recurrence. On an accepted start it captures the multiplicand and the multiplier and precomputes two operands: one to add and one to subtract. It then spends one clock per multiplier bit. In each step it looks at the two lowest bits of a wide working register and adds, subtracts or does nothing. It then shifts the register right arithmetically by one place.

When the last step is done, a one-cycle completion pulse marks the result. The product is the working register without its guard bit, truncated to the combined operand width. It stays on the output until the next accepted start.

The working and operand registers carry one extra accumulator bit above the multiplicand width. Because of this, negating the most negative multiplicand never wraps. The block is meant for datapaths that can wait a fixed number of cycles for a product and want a small area in return.

Top module: `booth_seq_mul`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes idle: `busy` = 0, `done` = 0 and `product` = 0. This also applies in the middle of an operation.
- R2: A clock edge that sees `start` = 1 with `busy` = 0 captures `x` and `y` and sets `busy` = 1 from the next cycle.
- R3: `done` is high for exactly one cycle. It rises at the YW-th clock edge after the accepting edge (8 for the default width), and `busy` falls at that same edge.
- R4: At `done`, `product` equals the signed product x*y as a 16-bit two's-complement value. The operands `x` and `y` are 8-bit two's complement, and bit 15 of `product` is its sign.
- R5: Operands at the limits give exact results. Examples: -128*-128 = 16384 (0x4000), -128*127 = -16256, 127*127 = 16129, and any value times 0 gives 0.
- R6: `start` and any change on `x`/`y` while `busy` = 1 have no effect: neither the result nor the cycle on which `done` appears changes.
- R7: After `done`, `product` holds its value, and `done` stays low, until the next accepted start, whatever `x` and `y` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a multiply; sampled only when idle |
| x | input | XW (8) | Multiplicand, two's complement |
| y | input | YW (8) | Multiplier, two's complement |
| busy | output | 1 | Booth steps in progress |
| done | output | 1 | One-cycle pulse: product valid |
| product | output | XW+YW (16) | Signed product, held until the next start |

## Verification
The only result is the product. It is due at the YW-th rising edge after the edge that accepts `start`, and `done` marks that cycle. The bench drives each request on a falling edge and checks at the falling edge after the accepting edge that `busy` is set. It then confirms at each of the next YW-1 falling edges that `done` is still low. It compares `done`, `busy` and `product` at the falling edge that follows the YW-th edge. Hold behaviour and ignored starts are checked at falling edges after the edges where an erroneous change would have shown.

// File: rtl/booth_pkg.sv
// Shared types for the sequential Booth multiplier.
// Assumes: none beyond the standard radix-2 recoding of a bit pair.
package booth_pkg;

    // Operation picked from the two lowest bits of the working register
    typedef enum logic [1:0] {
        BOP_NONE = 2'd0,
        BOP_ADD  = 2'd1,
        BOP_SUB  = 2'd2
    } booth_op_e;

    // Recode the bit pair {p[1], p[0]}: 01 adds, 10 subtracts, 00/11 idle
    function automatic booth_op_e booth_decode(input logic [1:0] pair);
        case (pair)
            2'b01:   return BOP_ADD;
            2'b10:   return BOP_SUB;
            default: return BOP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/booth_operand_prep.sv
// Builds the add operand, the subtract operand and the initial working value
// from the raw multiplicand and multiplier.
// Assumes: x and y are two's complement. The accumulator field is XW+1 bits
// wide, so the negation of the most negative x stays exact.
module booth_operand_prep #(
    parameter int XW = 8,
    parameter int YW = 8
) (
    input  logic [XW-1:0]      x,
    input  logic [YW-1:0]      y,
    output logic [XW+YW+1:0]   add_val,
    output logic [XW+YW+1:0]   sub_val,
    output logic [XW+YW+1:0]   p_init
);
    localparam int AW = XW + 1;     // accumulator field width
    localparam int LW = YW + 1;     // multiplier field plus guard bit

    logic [AW-1:0] x_ext;
    logic [AW-1:0] x_neg;

    // Sign-extend x by one bit and form its negation in the wider field
    always_comb begin
        x_ext = {x[XW-1], x};
        x_neg = AW'(~x_ext + AW'(1));
    end

    // Place the operands in the upper field; the low field starts empty or holds y
    always_comb begin
        add_val = {x_ext, {LW{1'b0}}};
        sub_val = {x_neg, {LW{1'b0}}};
        p_init  = {{AW{1'b0}}, y, 1'b0};
    end

endmodule

// File: rtl/booth_step.sv
// One radix-2 Booth step: conditional add or subtract, then arithmetic
// shift right by one place.
// Assumes: the operands were built by booth_operand_prep; carry out of the
// top bit is discarded.
module booth_step
    import booth_pkg::*;
#(
    parameter int W = 18
) (
    input  logic [W-1:0] p_in,
    input  logic [W-1:0] add_val,
    input  logic [W-1:0] sub_val,
    output logic [W-1:0] p_out
);
    booth_op_e     op;
    logic [W-1:0]  sum;

    // Pick the operation from the lowest bit pair and form the partial sum
    always_comb begin
        op = booth_decode(p_in[1:0]);
        case (op)
            BOP_ADD: sum = p_in + add_val;
            BOP_SUB: sum = p_in + sub_val;
            default: sum = p_in;
        endcase
    end

    // Shift right by one, replicating the sign bit
    always_comb begin
        p_out = {sum[W-1], sum[W-1:1]};
    end

endmodule

// File: rtl/booth_ctrl.sv
// Sequencer: accepts start when idle, counts YW step cycles and pulses
// done once after the last step.
// Assumes: start is a level sampled on each rising edge; it is ignored
// while busy.
module booth_ctrl #(
    parameter int YW = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step_en,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(YW + 1);

    logic [CW-1:0] steps_left;

    // Load on an accepted start; step in every busy cycle
    always_comb begin
        load    = start && !busy;
        step_en = busy;
    end

    // Step counter, busy flag and the single-cycle completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            done       <= 1'b0;
            steps_left <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                busy       <= 1'b1;
                steps_left <= CW'(YW);
            end else if (busy) begin
                steps_left <= steps_left - CW'(1);
                if (steps_left == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/booth_seq_mul.sv
// Top of the sequential radix-2 Booth multiplier. It holds the add and
// subtract operands and the working register, and runs one Booth step
// per clock while busy.
// Assumes: operands are two's complement; the product is valid while done
// is high and is held until the next accepted start.
module booth_seq_mul #(
    parameter int XW = 8,
    parameter int YW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [XW-1:0]      x,
    input  logic [YW-1:0]      y,
    output logic               busy,
    output logic               done,
    output logic [XW+YW-1:0]   product
);
    localparam int W  = XW + YW + 2;   // accumulator(XW+1) + y(YW) + guard(1)
    localparam int PW = XW + YW;

    logic          load;
    logic          step_en;
    logic [W-1:0]  add_q, sub_q, p_q;
    logic [W-1:0]  add_d, sub_d, p_init, p_next;

    booth_ctrl #(.YW(YW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .load    (load),
        .step_en (step_en),
        .busy    (busy),
        .done    (done)
    );

    booth_operand_prep #(.XW(XW), .YW(YW)) u_prep (
        .x       (x),
        .y       (y),
        .add_val (add_d),
        .sub_val (sub_d),
        .p_init  (p_init)
    );

    booth_step #(.W(W)) u_step (
        .p_in    (p_q),
        .add_val (add_q),
        .sub_val (sub_q),
        .p_out   (p_next)
    );

    // Operand and working registers: load on start, advance on each step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            add_q <= '0;
            sub_q <= '0;
            p_q   <= '0;
        end else if (load) begin
            add_q <= add_d;
            sub_q <= sub_d;
            p_q   <= p_init;
        end else if (step_en) begin
            p_q   <= p_next;
        end
    end

    // Drop the guard bit and keep the low PW bits of the signed result
    always_comb begin
        product = p_q[PW:1];
    end

endmodule

// File: rtl/booth_seq_mul_chk.sv
// Assertion checker for booth_seq_mul, bound to every instance.
// Assumes: same parameters as the bound instance.
module booth_seq_mul_chk #(
    parameter int XW = 8,
    parameter int YW = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [XW-1:0]      x,
    input logic [YW-1:0]      y,
    input logic               busy,
    input logic               done,
    input logic [XW+YW-1:0]   product
);
    localparam int PW = XW + YW;
    localparam int CW = $clog2(YW + 1) + 1;

    logic [CW-1:0] run_cnt;
    logic [XW-1:0] x_l;
    logic [YW-1:0] y_l;
    logic [PW-1:0] ref_prod;

    // Track cycles since the accepting edge and the captured operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            x_l     <= '0;
            y_l     <= '0;
        end else if (start && !busy) begin
            run_cnt <= '0;
            x_l     <= x;
            y_l     <= y;
        end else if (busy) begin
            run_cnt <= run_cnt + CW'(1);
        end
    end

    // Reference product from the captured operands
    always_comb begin
        ref_prod = PW'($signed({{YW{x_l[XW-1]}}, x_l}) * $signed({{XW{y_l[YW-1]}}, y_l}));
    end

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);  // R2
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == CW'(YW) && !busy));  // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R3
    AST_PRODUCT_OK: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (product == ref_prod));  // R4
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));  // R6
    AST_PRODUCT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));  // R7

endmodule

bind booth_seq_mul booth_seq_mul_chk #(.XW(XW), .YW(YW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .x       (x),
    .y       (y),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/tb_booth_seq_mul.sv
module tb_booth_seq_mul;
    localparam int CLK_PERIOD = 10;
    localparam int XW = 8;
    localparam int YW = 8;
    localparam int PW = XW + YW;
    localparam int WATCHDOG = 190000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [XW-1:0] x = '0;
    logic [YW-1:0] y = '0;
    logic          busy;
    logic          done;
    logic [PW-1:0] product;

    int n_vec = 0;
    int n_err = 0;
    int cyc = 0;

    booth_seq_mul #(.XW(XW), .YW(YW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .x(x), .y(y),
        .busy(busy), .done(done), .product(product)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc >= WATCHDOG) begin
            n_err = n_err + 1;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<%0d", cyc, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec = n_vec + 1;
        if (!ok) begin
            n_err = n_err + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] ref_mul(input logic [XW-1:0] a, input logic [YW-1:0] b);
        int p;
        p = int'($signed(a)) * int'($signed(b));
        return p[PW-1:0];
    endfunction

    // Full multiply with timing checks; optional mid-run start with other operands
    task automatic run_mul(input logic [XW-1:0] a, input logic [YW-1:0] b, input bit poke);
        logic [PW-1:0] e;
        bit early;
        e = ref_mul(a, b);
        early = 1'b0;
        @(negedge clk); start = 1'b1; x = a; y = b;
        @(negedge clk); start = 1'b0; x = ~a; y = ~b;
        if (!busy) chk(1'b0, "R2 busy after start", 32'(busy), 32'd1);
        for (int k = 0; k < YW - 1; k++) begin
            if (poke && k == 2) begin start = 1'b1; x = 8'h55; y = 8'h33; end
            else start = 1'b0;
            @(negedge clk);
            if (done) early = 1'b1;
        end
        start = 1'b0;
        if (early) chk(1'b0, "R3 done too early", 32'd1, 32'd0);
        @(negedge clk);
        chk(done && !busy, poke ? "R6 done timing with ignored start" : "R3 done timing",
            {done, busy}, 32'h2);
        chk(product == e, poke ? "R6 result with ignored start" : "R4/R5 product",
            32'(product), 32'(e));
    endtask

    initial begin
        logic [PW-1:0] held;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!busy && !done && product == '0, "R1 reset idle", {busy, done, product}, 32'd0);
        rst_n = 1'b1;

        // R5: limit operands
        run_mul(8'h80, 8'h80, 1'b0);
        run_mul(8'h80, 8'h7F, 1'b0);
        run_mul(8'h7F, 8'h80, 1'b0);
        run_mul(8'h7F, 8'h7F, 1'b0);
        run_mul(8'h80, 8'h00, 1'b0);
        run_mul(8'hFF, 8'hFF, 1'b0);
        run_mul(8'h80, 8'hFF, 1'b0);

        // R6: start while busy is ignored
        run_mul(8'hC3, 8'h5A, 1'b1);
        run_mul(8'h80, 8'h80, 1'b1);

        // R7: product held after done while inputs move
        held = product;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); x = 8'(k * 37); y = 8'(k * 91);
            @(negedge clk);
            chk(product == held && !done, "R7 product held", 32'(product), 32'(held));
        end

        // R1: reset in the middle of an operation
        @(negedge clk); start = 1'b1; x = 8'h12; y = 8'h34;
        @(negedge clk); start = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !done && product == '0, "R1 reset mid-run", {busy, done, product}, 32'd0);
        rst_n = 1'b1;

        // R4: every x against a spread of y values including the edges
        for (int xi = -128; xi < 128; xi++) begin
            for (int yi = -128; yi < 128; yi += 7) run_mul(8'(xi), 8'(yi), 1'b0);
            run_mul(8'(xi), 8'h7F, 1'b0);
            run_mul(8'(xi), 8'hFF, 1'b0);
            run_mul(8'(xi), 8'h00, 1'b0);
            run_mul(8'(xi), 8'h01, 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule